// File: doc/BRIEF.md
# Masked Packed Quadword-to-Doubleword Narrowing Unit

This block is one datapath stage of a SIMD execution pipe. It takes a source vector of up to eight 64-bit integer lanes and narrows each active lane to 32 bits. A lane can be narrowed in three ways: the high half can be dropped, the value can be clamped to the signed 32-bit range, or it can be clamped to the unsigned 32-bit range. The narrowed lanes are packed side by side from bit 0 upward. A per-lane write mask then decides which lanes take the new value. A lane that is not written either keeps the old destination contents or is cleared.

Two destination forms are supported. In the register form, unwritten lanes may be merged or zeroed, and every bit above the packed span is cleared. In the memory form, unwritten lanes always keep their old contents and nothing above the packed span changes. A byte-enable vector also reports which bytes a store would write. An encoding with a bad reserved field, an unknown opcode or an unsupported length raises an illegal flag, and the destination is left exactly as it was. A request presented with `in_valid` produces its result one clock later, flagged by `out_valid`.

Top module: `qnarrow_unit`

## Requirements
- R1: `in_vlen` selects the active lane count: 0 gives 2 lanes (128-bit source), 1 gives 4 lanes (256), 2 gives 8 lanes (512); code 3 is illegal (see R9).
- R2: Output lane j occupies `out_data[32j+31:32j]` and is computed from `in_src[64j+63:64j]`.
- R3: Opcode 8'h35 selects truncation: the result lane is the low 32 bits of the source lane.
- R4: Opcode 8'h25 selects signed saturation: values above 0x7FFFFFFF give 0x7FFFFFFF, values below -2^31 give 0x80000000, and all others pass through.
- R5: Opcode 8'h15 selects unsigned saturation: values above 0xFFFFFFFF give 0xFFFFFFFF, and all others pass through.
- R6: An active lane is written when `in_mask_en` is 0 or its mask bit is 1. Otherwise it keeps `in_old` if `in_zeroing` is 0, or becomes zero in the register form if `in_zeroing` is 1.
- R7: In the register form (`in_mem_form`=0), every output bit from half the source length up to bit 511 is zero, and `out_byte_en` is all zero.
- R8: In the memory form, `in_zeroing` has no effect. Unwritten lanes and all bits from half the source length upward equal `in_old`. Bits `out_byte_en[4j+3:4j]` are 1 exactly when lane j is written.
- R9: If `in_rsvd` is not 4'b1111, or the opcode is not one of the three codes, or `in_vlen` is 3, then `out_illegal` is 1, `out_data` equals `in_old` and `out_byte_en` is 0.
- R10: Mask bits at or above the active lane count have no effect on any output.
- R11: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. The outputs are registered, and a synchronous active-high `rst` clears `out_valid`, `out_illegal`, `out_data` and `out_byte_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_opcode | input | 8 | Conversion opcode (0x35, 0x25, 0x15) |
| in_rsvd | input | 4 | Reserved field, must be 4'b1111 |
| in_vlen | input | 2 | Source length code |
| in_mask_en | input | 1 | 1 enables the per-lane write mask |
| in_mask | input | 8 | Per-lane write mask |
| in_zeroing | input | 1 | 1 zeroes unwritten lanes (register form only) |
| in_mem_form | input | 1 | 1 selects the memory destination form |
| in_src | input | 512 | Packed 64-bit source lanes |
| in_old | input | 512 | Previous destination contents |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Illegal encoding detected |
| out_data | output | 512 | Narrowed, masked destination value |
| out_byte_en | output | 32 | Store byte enables (memory form) |

## Verification
The bench builds the unit with its default parameters: eight lanes, 64-bit sources and 32-bit results. With these values all three length codes and the reserved code 3 can be reached, and the region above the packed span is 256 bits wide. Every lane position and both treatments of the upper region can therefore be observed. The saturation cases place the exact signed and unsigned limits, and values one step beyond them, in separate lanes of one vector. The shortest length is driven with mask bits set above the active lanes, which shows that those bits are ignored.

// File: rtl/qnarrow_pkg.sv
package qnarrow_pkg;

    localparam int LANES_MAX  = 8;
    localparam int SRC_LANE_W = 64;
    localparam int DST_LANE_W = 32;
    localparam int VLEN_W     = 2;
    localparam int OPC_W      = 8;
    localparam int RSVD_W     = 4;

    localparam logic [OPC_W-1:0]  OPC_TRUNC = 8'h35;
    localparam logic [OPC_W-1:0]  OPC_SSAT  = 8'h25;
    localparam logic [OPC_W-1:0]  OPC_USAT  = 8'h15;
    localparam logic [RSVD_W-1:0] RSVD_OK   = 4'b1111;

    typedef enum logic [1:0] {
        NARROW_TRUNC = 2'd0,
        NARROW_SSAT  = 2'd1,
        NARROW_USAT  = 2'd2
    } narrow_mode_e;

    typedef struct packed {
        logic         illegal;
        narrow_mode_e mode;
        logic         mem_form;
        logic         zero_fill;
    } op_ctrl_t;

    function automatic logic opc_known(input logic [OPC_W-1:0] opc);
        return (opc == OPC_TRUNC) || (opc == OPC_SSAT) || (opc == OPC_USAT);
    endfunction

    function automatic narrow_mode_e opc_mode(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_SSAT: return NARROW_SSAT;
            OPC_USAT: return NARROW_USAT;
            default:  return NARROW_TRUNC;
        endcase
    endfunction

endpackage

// File: rtl/qnarrow_decode.sv
module qnarrow_decode
    import qnarrow_pkg::*;
#(
    parameter int LANES   = LANES_MAX,
    parameter int VLW     = VLEN_W
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [RSVD_W-1:0] rsvd,
    input  logic [VLW-1:0]    vlen,
    input  logic              mask_en,
    input  logic [LANES-1:0]  mask,
    input  logic              zeroing,
    input  logic              mem_form,
    output op_ctrl_t          ctrl,
    output logic [LANES-1:0]  lane_act,
    output logic [LANES-1:0]  lane_wr
);

    localparam int MAX_CODE = $clog2(LANES) - 1;

    logic vlen_ok;
    int   act_cnt;

    always_comb begin
        vlen_ok        = (int'(vlen) <= MAX_CODE);
        act_cnt        = 2 << int'(vlen);
        ctrl.illegal   = !vlen_ok || (rsvd != RSVD_OK) || !opc_known(opcode);
        ctrl.mode      = opc_mode(opcode);
        ctrl.mem_form  = mem_form;
        ctrl.zero_fill = zeroing && !mem_form;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_act
        assign lane_act[j] = vlen_ok && (j < act_cnt);
        assign lane_wr[j]  = lane_act[j] && !ctrl.illegal && (mask[j] || !mask_en);
    end

endmodule

// File: rtl/qnarrow_lane.sv
module qnarrow_lane
    import qnarrow_pkg::*;
#(
    parameter int SRC_W = SRC_LANE_W,
    parameter int DST_W = DST_LANE_W
) (
    input  narrow_mode_e     mode,
    input  logic [SRC_W-1:0] src,
    output logic [DST_W-1:0] dst
);

    localparam int HI_W = SRC_W - DST_W;

    logic hi_zero;
    logic fits_signed;

    always_comb begin
        hi_zero     = (src[SRC_W-1:DST_W] == '0);
        fits_signed = (src[SRC_W-1:DST_W-1] == '0) || (src[SRC_W-1:DST_W-1] == '1);
        case (mode)
            NARROW_SSAT: begin
                if (fits_signed)
                    dst = src[DST_W-1:0];
                else if (src[SRC_W-1])
                    dst = {1'b1, {(DST_W-1){1'b0}}};
                else
                    dst = {1'b0, {(DST_W-1){1'b1}}};
            end
            NARROW_USAT: dst = hi_zero ? src[DST_W-1:0] : '1;
            default:     dst = src[DST_W-1:0];
        endcase
    end

    always_comb begin
        AST_SSAT_SIGN: assert (mode != NARROW_SSAT || dst[DST_W-1] == src[SRC_W-1])
            else $error("signed result sign differs from source");  // R4
        AST_USAT_NO_WRAP: assert (mode != NARROW_USAT || {{HI_W{1'b0}}, dst} <= src)
            else $error("unsigned result exceeds source");  // R5
    end

endmodule

// File: rtl/qnarrow_merge.sv
module qnarrow_merge
    import qnarrow_pkg::*;
#(
    parameter int LANES = LANES_MAX,
    parameter int SRC_W = SRC_LANE_W,
    parameter int DST_W = DST_LANE_W
) (
    input  op_ctrl_t                       ctrl,
    input  logic [LANES-1:0]               lane_act,
    input  logic [LANES-1:0]               lane_wr,
    input  logic [LANES*DST_W-1:0]         conv,
    input  logic [LANES*SRC_W-1:0]         old,
    output logic [LANES*SRC_W-1:0]         data,
    output logic [LANES*(DST_W/8)-1:0]     byte_en
);

    localparam int VEC_W  = LANES * SRC_W;
    localparam int SPAN_W = LANES * DST_W;
    localparam int BPL    = DST_W / 8;

    for (genvar j = 0; j < LANES; j++) begin : g_sel
        logic [DST_W-1:0] old_lane;
        logic [DST_W-1:0] lane_val;
        assign old_lane = old[j*DST_W +: DST_W];
        always_comb begin
            if (ctrl.illegal)
                lane_val = old_lane;
            else if (lane_wr[j])
                lane_val = conv[j*DST_W +: DST_W];
            else if (lane_act[j])
                lane_val = ctrl.zero_fill ? '0 : old_lane;
            else
                lane_val = ctrl.mem_form ? old_lane : '0;
        end
        assign data[j*DST_W +: DST_W] = lane_val;
        assign byte_en[j*BPL +: BPL]  = {BPL{ctrl.mem_form && lane_wr[j]}};
    end

    if (VEC_W > SPAN_W) begin : g_upper
        assign data[VEC_W-1:SPAN_W] = (ctrl.illegal || ctrl.mem_form) ? old[VEC_W-1:SPAN_W] : '0;
    end

endmodule

// File: rtl/qnarrow_unit.sv
module qnarrow_unit
    import qnarrow_pkg::*;
#(
    parameter int MAX_LANES = LANES_MAX,
    parameter int SRC_W     = SRC_LANE_W,
    parameter int DST_W     = DST_LANE_W,
    parameter int VLW       = VLEN_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [OPC_W-1:0]                in_opcode,
    input  logic [RSVD_W-1:0]               in_rsvd,
    input  logic [VLW-1:0]                  in_vlen,
    input  logic                            in_mask_en,
    input  logic [MAX_LANES-1:0]            in_mask,
    input  logic                            in_zeroing,
    input  logic                            in_mem_form,
    input  logic [MAX_LANES*SRC_W-1:0]      in_src,
    input  logic [MAX_LANES*SRC_W-1:0]      in_old,
    output logic                            out_valid,
    output logic                            out_illegal,
    output logic [MAX_LANES*SRC_W-1:0]      out_data,
    output logic [MAX_LANES*(DST_W/8)-1:0]  out_byte_en
);

    localparam int VEC_W  = MAX_LANES * SRC_W;
    localparam int SPAN_W = MAX_LANES * DST_W;
    localparam int BE_W   = MAX_LANES * (DST_W / 8);

    op_ctrl_t                 ctrl;
    logic [MAX_LANES-1:0]     lane_act;
    logic [MAX_LANES-1:0]     lane_wr;
    logic [SPAN_W-1:0]        conv;
    logic [VEC_W-1:0]         nxt_data;
    logic [BE_W-1:0]          nxt_be;

    qnarrow_decode #(.LANES(MAX_LANES), .VLW(VLW)) u_decode (
        .opcode   (in_opcode),
        .rsvd     (in_rsvd),
        .vlen     (in_vlen),
        .mask_en  (in_mask_en),
        .mask     (in_mask),
        .zeroing  (in_zeroing),
        .mem_form (in_mem_form),
        .ctrl     (ctrl),
        .lane_act (lane_act),
        .lane_wr  (lane_wr)
    );

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        qnarrow_lane #(.SRC_W(SRC_W), .DST_W(DST_W)) u_lane (
            .mode (ctrl.mode),
            .src  (in_src[j*SRC_W +: SRC_W]),
            .dst  (conv[j*DST_W +: DST_W])
        );
    end

    qnarrow_merge #(.LANES(MAX_LANES), .SRC_W(SRC_W), .DST_W(DST_W)) u_merge (
        .ctrl     (ctrl),
        .lane_act (lane_act),
        .lane_wr  (lane_wr),
        .conv     (conv),
        .old      (in_old),
        .data     (nxt_data),
        .byte_en  (nxt_be)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_data    <= '0;
            out_byte_en <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal <= ctrl.illegal;
                out_data    <= nxt_data;
                out_byte_en <= nxt_be;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R11
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R11
    AST_BAD_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_rsvd != RSVD_OK) |=> out_illegal && (out_byte_en == '0) && (out_data == $past(in_old)));  // R9
    AST_MEM_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_mem_form |=> out_data[VEC_W-1:SPAN_W] == $past(in_old[VEC_W-1:SPAN_W]));  // R8
    AST_REG_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_mem_form && (in_rsvd == RSVD_OK) && (in_opcode == OPC_TRUNC) && (in_vlen != '1)
        |=> out_data[VEC_W-1:SPAN_W] == '0);  // R7
    AST_REG_NO_BYTE_EN: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_mem_form |=> out_byte_en == '0);  // R7

endmodule

// File: tb/qnarrow_unit_bench.sv
`timescale 1ns/1ps
module qnarrow_unit_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [7:0]   in_opcode = 8'h35;
    logic [3:0]   in_rsvd = 4'hF;
    logic [1:0]   in_vlen = 2'd2;
    logic         in_mask_en = 1'b0;
    logic [7:0]   in_mask = 8'h00;
    logic         in_zeroing = 1'b0;
    logic         in_mem_form = 1'b0;
    logic [511:0] in_src = '0;
    logic [511:0] in_old = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [511:0] out_data;
    logic [31:0]  out_byte_en;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    qnarrow_unit u_qnarrow_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_rsvd(in_rsvd), .in_vlen(in_vlen), .in_mask_en(in_mask_en),
        .in_mask(in_mask), .in_zeroing(in_zeroing), .in_mem_form(in_mem_form),
        .in_src(in_src), .in_old(in_old), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_data(out_data), .out_byte_en(out_byte_en)
    );

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] narrow_ref(input logic [7:0] opc, input logic [63:0] s);
        if (opc == 8'h25) begin
            if ($signed(s) > 64'sh7FFFFFFF) return 32'h7FFFFFFF;
            if ($signed(s) < -64'sh80000000) return 32'h80000000;
            return s[31:0];
        end
        if (opc == 8'h15) return (s > 64'hFFFFFFFF) ? 32'hFFFFFFFF : s[31:0];
        return s[31:0];
    endfunction

    task automatic model(output logic [511:0] d, output logic [31:0] be, output logic ill);
        int n;
        ill = (in_rsvd != 4'hF) || (in_vlen == 2'd3) ||
              !((in_opcode == 8'h35) || (in_opcode == 8'h25) || (in_opcode == 8'h15));
        n  = 2 << in_vlen;
        d  = in_old;
        be = '0;
        if (!ill) begin
            if (!in_mem_form) d[511:256] = '0;
            for (int j = 0; j < 8; j++) begin
                if (j >= n) begin
                    if (!in_mem_form) d[j*32 +: 32] = '0;
                end else if (!in_mask_en || in_mask[j]) begin
                    d[j*32 +: 32] = narrow_ref(in_opcode, in_src[j*64 +: 64]);
                    if (in_mem_form) be[j*4 +: 4] = 4'hF;
                end else if (in_zeroing && !in_mem_form) begin
                    d[j*32 +: 32] = '0;
                end
            end
        end
    endtask

    task automatic run_op(input string tag);
        logic [511:0] ed;
        logic [31:0]  eb;
        logic         ei;
        model(ed, eb, ei);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R11 valid"}, {511'd0, out_valid}, 512'd1);
        check({tag, " data"}, out_data, ed);
        check({tag, " byte_en"}, {480'd0, out_byte_en}, {480'd0, eb});
        check({tag, " illegal"}, {511'd0, out_illegal}, {511'd0, ei});
    endtask

    function automatic logic [511:0] pattern(input logic [63:0] seed);
        logic [511:0] v;
        for (int j = 0; j < 8; j++) v[j*64 +: 64] = seed * 64'(j + 3) ^ {seed[31:0], seed[63:32]};
        return v;
    endfunction

    task automatic t_reset;
        check("R11 reset valid", {511'd0, out_valid}, 512'd0);
        check("R11 reset illegal", {511'd0, out_illegal}, 512'd0);
        check("R11 reset data", out_data, 512'd0);
        check("R11 reset byte_en", {480'd0, out_byte_en}, 512'd0);
    endtask

    task automatic t_trunc;
        in_opcode = 8'h35; in_vlen = 2'd2; in_mask_en = 1'b0; in_mem_form = 1'b0;
        in_src = pattern(64'h0123_4567_89AB_CDEF); in_old = {512{1'b1}};
        run_op("R3 R2 R1 trunc 512");
        in_vlen = 2'd1; in_src = pattern(64'hDEAD_BEEF_0BAD_F00D);
        run_op("R3 R1 trunc 256");
    endtask

    task automatic t_ssat;
        in_opcode = 8'h25; in_vlen = 2'd2; in_mask_en = 1'b0; in_mem_form = 1'b0;
        in_src = {64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000,
                  64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF,
                  64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1234};
        in_old = pattern(64'h5555);
        run_op("R4 ssat corners");
    endtask

    task automatic t_usat;
        in_opcode = 8'h15; in_vlen = 2'd2; in_mask_en = 1'b0; in_mem_form = 1'b0;
        in_src = {64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000,
                  64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                  64'h0000_0000_8000_0001, 64'h8000_0000_0000_0000,
                  64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0042};
        run_op("R5 usat corners");
    endtask

    task automatic t_merge_zero;
        in_opcode = 8'h35; in_vlen = 2'd1; in_mask_en = 1'b1; in_mask = 8'b0000_0101;
        in_zeroing = 1'b0; in_mem_form = 1'b0;
        in_src = pattern(64'hAAAA_0000_1111_2222); in_old = pattern(64'h7777_6666);
        run_op("R6 R7 merge reg 256");
        in_zeroing = 1'b1;
        run_op("R6 zeroing reg 256");
        in_zeroing = 1'b0; in_mask_en = 1'b0; in_mask = 8'h00;
        run_op("R6 mask disabled");
    endtask

    task automatic t_mem;
        in_opcode = 8'h25; in_vlen = 2'd1; in_mask_en = 1'b1; in_mask = 8'b0000_1010;
        in_zeroing = 1'b1; in_mem_form = 1'b1;
        in_src = pattern(64'hF0F0_1234_0000_9999); in_old = pattern(64'h3333_CCCC);
        run_op("R8 mem zeroing ignored 256");
        in_vlen = 2'd2; in_mask = 8'b1100_0001; in_zeroing = 1'b0;
        run_op("R8 mem merge 512");
    endtask

    task automatic t_upper_mask;
        in_opcode = 8'h15; in_vlen = 2'd0; in_mask_en = 1'b1; in_mask = 8'b1111_1110;
        in_zeroing = 1'b0; in_mem_form = 1'b0;
        in_src = pattern(64'h0000_0002_0000_0003); in_old = pattern(64'h1357_9BDF);
        run_op("R10 R1 reg 128 upper mask bits");
        in_mem_form = 1'b1;
        run_op("R10 mem 128 upper mask bits");
    endtask

    task automatic t_illegal;
        in_opcode = 8'h35; in_vlen = 2'd2; in_mask_en = 1'b0; in_mem_form = 1'b0;
        in_src = pattern(64'h9999); in_old = pattern(64'hBEEF);
        in_rsvd = 4'b1110;
        run_op("R9 bad rsvd");
        in_rsvd = 4'hF; in_opcode = 8'h45; in_mem_form = 1'b1;
        run_op("R9 bad opcode");
        in_opcode = 8'h25; in_vlen = 2'd3;
        run_op("R9 R1 vlen 3");
        in_vlen = 2'd2;
    endtask

    task automatic t_latency;
        logic [511:0] held;
        in_opcode = 8'h35; in_mem_form = 1'b0; in_mask_en = 1'b0;
        in_src = pattern(64'h4242); in_old = '0;
        run_op("R11 single op");
        held = out_data;
        in_src = pattern(64'h1111);
        @(negedge clk);
        check("R11 valid drops", {511'd0, out_valid}, 512'd0);
        check("R11 data held", out_data, held);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        @(negedge clk);
        t_trunc();
        t_ssat();
        t_usat();
        t_merge_zero();
        t_mem();
        t_upper_mask();
        t_illegal();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule